// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is the master side of a single open-drain data line held high by a pull-up. A host hands it one command at a time. The block then produces the line activity for that command. A bus reset is a long low pulse followed by a listening window for a presence reply. A write slot carries one bit, and a read slot samples one bit. The byte commands run eight slots back to back, least significant bit first. The block never drives the line high. It only asserts a low-enable toward an open-drain pad and samples the resolved line level on a separate input.

All timing comes from a microsecond timebase built from the system clock, using `TICKS_PER_US` clocks per microsecond. Every window is a whole number of microseconds. After a byte write, the host may ask for a strong pull-up. It is enabled as soon as the eighth slot ends and is held for `SPU_US` microseconds, and no slot runs during that time. The command is not finished until the strong pull-up is released.

Top module: `sw_bus_master`

## Requirements
- R1: While `rst_n` is low, and after it until the first command, `drive_low`, `spu_en`, `busy`, `done`, `presence` and `rsp_data` are all 0.
- R2: A command is accepted on a clock where `cmd_valid` is 1, the block is idle and `cmd_op` is 1 (bus reset), 2 (write bit), 3 (read bit), 4 (write byte) or 5 (read byte). The line goes low on the next clock. `busy` stays 1 until the clock on which `done` pulses for exactly one cycle. Codes 0, 6 and 7 are ignored, and so is any `cmd_valid` seen while busy.
- R3: A bus reset holds the line low for 500 µs and then releases it. It samples the line 70 µs after the release and finishes 1000 µs after it began. `presence` becomes 1 if the sampled line was low and 0 otherwise.
- R4: A write slot holds the line low for 6 µs to send a 1 (bit 0 of `cmd_data` for a write bit) or for 60 µs to send a 0. It finishes 72 µs after it began, which is a 70 µs slot plus 2 µs of recovery with the line released.
- R5: A read slot holds the line low for 1 µs and samples the line 12 µs after the slot began. It finishes at 72 µs. A read bit returns the sample in `rsp_data[0]`, with bits 7..1 cleared.
- R6: A byte command runs eight slots back to back, each starting 72 µs after the previous one. A write byte sends `cmd_data[0]` first and `cmd_data[7]` last. A read byte stores the first bit received in `rsp_data[0]` and the last in `rsp_data[7]`.
- R7: A write byte with `cmd_spu` = 1 raises `spu_en` 70 µs into its eighth slot and holds it for `SPU_US` µs. `spu_en` and `busy` then fall and `done` pulses on the same clock. `drive_low` stays 0 throughout.
- R8: `cmd_spu` has no effect on any command other than write byte.
- R9: Every duration is a microsecond count multiplied by `TICKS_PER_US` clock cycles.
- R10: `drive_low` and `spu_en` are never 1 together, and `drive_low` is 1 only while `busy` is 1. Each low pulse lasts at least 1 µs, and the line is released for at least 2 µs between consecutive low pulses.
- R11: `presence` changes only when a bus reset finishes, and `rsp_data` changes only when a read command finishes. Each holds its value in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_data | input | 8 | Bit (in bit 0) or byte to write |
| cmd_spu | input | 1 | Request strong pull-up after a byte write |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command finishes |
| presence | output | 1 | Result of the last bus reset |
| rsp_data | output | 8 | Result of the last read command |
| line_in | input | 1 | Resolved level of the data line |
| drive_low | output | 1 | Enable for the open-drain pull-down |
| spu_en | output | 1 | Enable for the strong pull-up |

## Verification
The hardest case to reach is the hand-off into the strong pull-up. It happens only in the eighth slot of a byte write. It falls 2 µs before the recovery point where a slot would normally end, and two outputs must change on one edge without overlapping. The bench reaches it by issuing a byte write with the pull-up request, using a shortened hold time. A responder model on the wired-AND line returns a presence pulse after long low pulses and pulls read slots low from a queued bit pattern. This exercises both polarities of the sampled result, and a behavioural model predicts every output on every clock.

// File: rtl/sw_pkg.sv
// Shared command codes and small enumerations for the single-wire bus master.
// Assumes command codes are 3 bits wide; codes outside 1..5 are not commands.
package sw_pkg;

    localparam logic [2:0] OP_RESET = 3'd1;
    localparam logic [2:0] OP_WBIT  = 3'd2;
    localparam logic [2:0] OP_RBIT  = 3'd3;
    localparam logic [2:0] OP_WBYTE = 3'd4;
    localparam logic [2:0] OP_RBYTE = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SLOT,
        ST_SPU
    } sw_state_e;

    typedef enum logic [1:0] {
        KIND_RST,
        KIND_W0,
        KIND_W1,
        KIND_RD
    } sw_kind_e;

endpackage

// File: rtl/sw_us_timer.sv
// Microsecond timebase: a prescaler of TICKS_PER_US clocks and an elapsed-us count.
// Assumes the owner clears it on the edge that starts a timed phase; the count
// may wrap while nothing is timed, which the owner ignores.
module sw_us_timer #(
    parameter int TICKS_PER_US = 4,
    parameter int US_W         = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic            tick,
    output logic [US_W-1:0] us
);
    localparam int PRE_W = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;

    logic [PRE_W-1:0] pre;

    assign tick = (pre == PRE_W'(TICKS_PER_US - 1));

    // Advance the prescaler and bump the microsecond count on its wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre <= '0;
            us  <= '0;
        end else if (tick) begin
            pre <= '0;
            us  <= us + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/sw_slot_decode.sv
// Turns the elapsed-us count of the current slot into event strobes: release,
// sample, end of slot proper, and end including recovery. Purely combinational.
// Assumes the timer was cleared on the edge where the slot started, so an
// event at n us fires on the edge exactly n*TICKS_PER_US clocks later.
module sw_slot_decode
    import sw_pkg::*;
#(
    parameter int US_W       = 10,
    parameter int RST_LOW_US = 500,
    parameter int RST_SMP_US = 70,
    parameter int RST_WIN_US = 500,
    parameter int W1_LOW_US  = 6,
    parameter int W0_LOW_US  = 60,
    parameter int RD_LOW_US  = 1,
    parameter int RD_SMP_US  = 12,
    parameter int SLOT_US    = 70,
    parameter int REC_US     = 2
) (
    input  sw_kind_e        kind,
    input  logic            tick,
    input  logic [US_W-1:0] us,
    output logic            rel_hit,
    output logic            smp_hit,
    output logic            bit_hit,
    output logic            end_hit
);
    logic [31:0] us_next;
    logic [31:0] low_n, smp_n, fin_n;
    logic        has_smp;

    assign us_next = 32'(us) + 32'd1;

    // Pick the event times that belong to the slot kind.
    always_comb begin
        case (kind)
            KIND_RST: begin
                low_n = 32'(RST_LOW_US);
                smp_n = 32'(RST_LOW_US + RST_SMP_US);
                fin_n = 32'(RST_LOW_US + RST_WIN_US);
                has_smp = 1'b1;
            end
            KIND_W0: begin
                low_n = 32'(W0_LOW_US);
                smp_n = 32'd0;
                fin_n = 32'(SLOT_US + REC_US);
                has_smp = 1'b0;
            end
            KIND_W1: begin
                low_n = 32'(W1_LOW_US);
                smp_n = 32'd0;
                fin_n = 32'(SLOT_US + REC_US);
                has_smp = 1'b0;
            end
            default: begin
                low_n = 32'(RD_LOW_US);
                smp_n = 32'(RD_SMP_US);
                fin_n = 32'(SLOT_US + REC_US);
                has_smp = 1'b1;
            end
        endcase
    end

    // Strobe each event on the tick that completes its microsecond.
    always_comb begin
        rel_hit = tick && (us_next == low_n);
        smp_hit = tick && has_smp && (us_next == smp_n);
        bit_hit = tick && (us_next == 32'(SLOT_US));
        end_hit = tick && (us_next == fin_n);
    end
endmodule

// File: rtl/sw_bus_master.sv
// Single-wire bus master: runs one host command at a time (bus reset, bit or
// byte write/read, LSB first) on an open-drain line and returns the result.
// Assumes line_in is the resolved wired-AND level, synchronised by the caller.
// Optional strong pull-up follows a byte write for SPU_US microseconds.
module sw_bus_master
    import sw_pkg::*;
#(
    parameter int TICKS_PER_US = 4,
    parameter int RST_LOW_US   = 500,
    parameter int RST_SMP_US   = 70,
    parameter int RST_WIN_US   = 500,
    parameter int W1_LOW_US    = 6,
    parameter int W0_LOW_US    = 60,
    parameter int RD_LOW_US    = 1,
    parameter int RD_SMP_US    = 12,
    parameter int SLOT_US      = 70,
    parameter int REC_US       = 2,
    parameter int SPU_US       = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic [7:0] cmd_data,
    input  logic       cmd_spu,
    output logic       busy,
    output logic       done,
    output logic       presence,
    output logic [7:0] rsp_data,
    input  logic       line_in,
    output logic       drive_low,
    output logic       spu_en
);
    localparam int RST_SPAN = RST_LOW_US + RST_WIN_US;
    localparam int BIT_SPAN = SLOT_US + REC_US;
    localparam int MAX_A    = (RST_SPAN > BIT_SPAN) ? RST_SPAN : BIT_SPAN;
    localparam int MAX_US   = (SPU_US > MAX_A) ? SPU_US : MAX_A;
    localparam int US_W     = $clog2(MAX_US + 1);

    sw_state_e       state;
    logic [2:0]      op_q;
    logic [7:0]      tx_q;
    logic [7:0]      rx_q;
    logic [2:0]      bit_cnt;
    logic            spu_q;
    sw_kind_e        kind;
    logic            tick;
    logic [US_W-1:0] us;
    logic            rel_hit, smp_hit, bit_hit, end_hit;
    logic            accept, is_byte, last_bit, spu_go, spu_hit, next_bit, tmr_clr;

    assign busy     = (state != ST_IDLE);
    assign accept   = (state == ST_IDLE) && cmd_valid &&
                      (cmd_op >= OP_RESET) && (cmd_op <= OP_RBYTE);
    assign is_byte  = (op_q == OP_WBYTE) || (op_q == OP_RBYTE);
    assign last_bit = !is_byte || (bit_cnt == 3'd7);
    assign spu_go   = (state == ST_SLOT) && (op_q == OP_WBYTE) && spu_q && last_bit && bit_hit;
    assign next_bit = (state == ST_SLOT) && end_hit && !last_bit;
    assign spu_hit  = tick && ((32'(us) + 32'd1) == 32'(SPU_US));
    assign tmr_clr  = accept || spu_go || next_bit;

    // Select the slot shape from the command and the bit being sent.
    always_comb begin
        if (op_q == OP_RESET)
            kind = KIND_RST;
        else if ((op_q == OP_RBIT) || (op_q == OP_RBYTE))
            kind = KIND_RD;
        else
            kind = tx_q[0] ? KIND_W1 : KIND_W0;
    end

    sw_us_timer #(
        .TICKS_PER_US(TICKS_PER_US),
        .US_W        (US_W)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .tick (tick),
        .us   (us)
    );

    sw_slot_decode #(
        .US_W      (US_W),
        .RST_LOW_US(RST_LOW_US),
        .RST_SMP_US(RST_SMP_US),
        .RST_WIN_US(RST_WIN_US),
        .W1_LOW_US (W1_LOW_US),
        .W0_LOW_US (W0_LOW_US),
        .RD_LOW_US (RD_LOW_US),
        .RD_SMP_US (RD_SMP_US),
        .SLOT_US   (SLOT_US),
        .REC_US    (REC_US)
    ) u_decode (
        .kind   (kind),
        .tick   (tick),
        .us     (us),
        .rel_hit(rel_hit),
        .smp_hit(smp_hit),
        .bit_hit(bit_hit),
        .end_hit(end_hit)
    );

    // Command sequencer: slot stepping, shifting, pull-up hold and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op_q      <= '0;
            tx_q      <= '0;
            rx_q      <= '0;
            bit_cnt   <= '0;
            spu_q     <= 1'b0;
            done      <= 1'b0;
            presence  <= 1'b0;
            rsp_data  <= '0;
            drive_low <= 1'b0;
            spu_en    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state     <= ST_SLOT;
                        op_q      <= cmd_op;
                        tx_q      <= cmd_data;
                        spu_q     <= cmd_spu && (cmd_op == OP_WBYTE);
                        bit_cnt   <= '0;
                        drive_low <= 1'b1;
                    end
                end
                ST_SLOT: begin
                    if (rel_hit)
                        drive_low <= 1'b0;
                    if (smp_hit)
                        rx_q <= {line_in, rx_q[7:1]};
                    if (spu_go) begin
                        state  <= ST_SPU;
                        spu_en <= 1'b1;
                    end else if (end_hit) begin
                        if (!last_bit) begin
                            bit_cnt   <= bit_cnt + 3'd1;
                            tx_q      <= {1'b0, tx_q[7:1]};
                            drive_low <= 1'b1;
                        end else begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                            if (op_q == OP_RESET)
                                presence <= !rx_q[7];
                            else if (op_q == OP_RBIT)
                                rsp_data <= {7'd0, rx_q[7]};
                            else if (op_q == OP_RBYTE)
                                rsp_data <= rx_q;
                        end
                    end
                end
                ST_SPU: begin
                    if (spu_hit) begin
                        spu_en <= 1'b0;
                        state  <= ST_IDLE;
                        done   <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sw_bus_master_chk.sv
// Property checker for sw_bus_master, attached by bind. Watches the host
// handshake, line enables and result registers; run-length counters replace
// long $past windows for the pulse-width rules.
module sw_bus_master_chk #(
    parameter int TICKS_PER_US = 4,
    parameter int RD_LOW_US    = 1,
    parameter int REC_US       = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       busy,
    input logic       done,
    input logic       presence,
    input logic [7:0] rsp_data,
    input logic       drive_low,
    input logic       spu_en
);
    logic [31:0] low_run;
    logic [31:0] high_run;
    logic        seen_low;

    // Count consecutive low-enable and released cycles of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run  <= '0;
            high_run <= '0;
            seen_low <= 1'b0;
        end else begin
            low_run  <= drive_low ? low_run + 32'd1 : 32'd0;
            high_run <= drive_low ? 32'd0 : high_run + 32'd1;
            if (drive_low)
                seen_low <= 1'b1;
        end
    end

    // R10
    enables_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_low && spu_en));

    // R10
    low_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> busy);

    // R10
    min_low_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_low) |-> (low_run >= 32'(RD_LOW_US * TICKS_PER_US)));

    // R10
    min_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_low) |-> (!seen_low || (high_run >= 32'(REC_US * TICKS_PER_US))));

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    busy_ends_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && (cmd_op >= 3'd1) && (cmd_op <= 3'd5)) |=> (busy && drive_low));

    // R2
    bad_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && ((cmd_op == 3'd0) || (cmd_op > 3'd5))) |=> !busy);

    // R7
    spu_ends_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spu_en) |-> done);

    // R11
    presence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(presence));

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rsp_data));
endmodule

bind sw_bus_master sw_bus_master_chk #(
    .TICKS_PER_US(TICKS_PER_US),
    .RD_LOW_US   (RD_LOW_US),
    .REC_US      (REC_US)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .busy     (busy),
    .done     (done),
    .presence (presence),
    .rsp_data (rsp_data),
    .drive_low(drive_low),
    .spu_en   (spu_en)
);

// File: tb/sim_sw_bus_master.sv
// Bench for sw_bus_master: pull-up line model with a responder, and a
// behavioural per-clock model of every output compared on each falling edge.
module sim_sw_bus_master;
    localparam int TPU   = 2;   // R9: every expected window below is us * TPU
    localparam int SPU_T = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       cmd_spu = 1'b0;
    logic       busy, done, presence, drive_low, spu_en, line_in;
    logic [7:0] rsp_data;

    logic       slave_pull = 1'b0;
    bit         slave_on = 1'b0;
    bit         rd_bits[$];

    int nvec = 0;
    int nbad = 0;

    always #2 clk = ~clk;

    assign line_in = (drive_low || slave_pull) ? 1'b0 : 1'b1;

    sw_bus_master #(.TICKS_PER_US(TPU), .SPU_US(SPU_T)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_spu(cmd_spu), .busy(busy), .done(done),
        .presence(presence), .rsp_data(rsp_data), .line_in(line_in),
        .drive_low(drive_low), .spu_en(spu_en)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Inputs as seen by the design at each rising edge.
    logic       rst_pre = 1'b0, cv_pre = 1'b0, spu_pre = 1'b0, line_pre = 1'b1;
    logic [2:0] op_pre = 3'd0;
    logic [7:0] dat_pre = 8'd0;
    always @(posedge clk) begin
        rst_pre  <= rst_n;
        cv_pre   <= cmd_valid;
        op_pre   <= cmd_op;
        dat_pre  <= cmd_data;
        spu_pre  <= cmd_spu;
        line_pre <= line_in;
    end

    // Responder: presence after a long low, zero bits from the queue on reads.
    int s_wait = 0, s_left = 0, mrun = 0;
    logic dl_q = 1'b0;
    bit s_b;
    always @(negedge clk) begin
        if (!rst_n) begin
            slave_pull = 1'b0; s_wait = 0; s_left = 0; mrun = 0; dl_q = 1'b0;
        end else begin
            if (s_left > 0) begin
                s_left--;
                if (s_left == 0) slave_pull = 1'b0;
            end
            if (s_wait > 0) begin
                s_wait--;
                if (s_wait == 0) begin slave_pull = 1'b1; s_left = 120 * TPU; end
            end
            if (drive_low && !dl_q && rd_bits.size() > 0) begin
                s_b = rd_bits.pop_front();
                if (!s_b) begin slave_pull = 1'b1; s_left = 20 * TPU; end
            end
            if (!drive_low && dl_q && mrun >= 400 * TPU && slave_on)
                s_wait = 30 * TPU;
            mrun = drive_low ? mrun + 1 : 0;
            dl_q = drive_low;
        end
    end

    function automatic int low_len(input int op, input bit b);
        if (op == 1) return 500;
        if (op == 3 || op == 5) return 1;
        return b ? 6 : 60;
    endfunction

    // Reference model: predicts outputs after each rising edge.
    int m_state = 0, m_op = 0, m_bit = 0, m_k = 0;
    logic [7:0] m_data = 0, m_rx = 0;
    bit   m_spu = 0, m_smp = 0, cur_b;
    logic e_drive = 0, e_spu = 0, e_done = 0, e_pres = 0;
    logic [7:0] e_rsp = 0;
    string dl_tag;
    always @(negedge clk) begin
        if (!rst_pre) begin
            m_state = 0; e_drive = 0; e_spu = 0; e_done = 0; e_pres = 0; e_rsp = 0;
        end else begin
            e_done = 0;
            if (m_state == 0) begin
                if (cv_pre && op_pre >= 3'd1 && op_pre <= 3'd5) begin
                    m_state = 1; m_op = int'(op_pre); m_data = dat_pre;
                    m_spu = spu_pre && (op_pre == 3'd4); m_bit = 0; m_k = 0; m_rx = 0;
                    e_drive = 1;
                end
            end else if (m_state == 1) begin
                m_k++;
                cur_b = (m_op == 2) ? m_data[0] : m_data[m_bit];
                if (m_k == low_len(m_op, cur_b) * TPU) e_drive = 0;
                if (m_op == 1 && m_k == 570 * TPU) m_smp = line_pre;
                if ((m_op == 3 || m_op == 5) && m_k == 12 * TPU) m_rx[m_bit] = line_pre;
                if (m_op == 4 && m_spu && m_bit == 7 && m_k == 70 * TPU) begin
                    m_state = 2; m_k = 0; e_spu = 1;
                end else if (m_k == ((m_op == 1) ? 1000 : 72) * TPU) begin
                    if ((m_op == 4 || m_op == 5) && m_bit < 7) begin
                        m_bit++; m_k = 0; e_drive = 1;
                    end else begin
                        m_state = 0; e_done = 1;
                        if (m_op == 1) e_pres = !m_smp;
                        if (m_op == 3) e_rsp = {7'd0, m_rx[0]};
                        if (m_op == 5) e_rsp = m_rx;
                    end
                end
            end else begin
                m_k++;
                if (m_k == SPU_T * TPU) begin m_state = 0; e_spu = 0; e_done = 1; end
            end
            case (m_op)
                1: dl_tag = "R3 R9";
                2: dl_tag = "R4 R9";
                3: dl_tag = "R5 R9";
                default: dl_tag = "R6 R9";
            endcase
            chk(dl_tag, "drive_low", 32'(drive_low), 32'(e_drive));
            chk("R7 R8", "spu_en", 32'(spu_en), 32'(e_spu));
            chk("R2", "busy", 32'(busy), 32'(m_state != 0));
            chk("R2", "done", 32'(done), 32'(e_done));
            chk("R3 R11", "presence", 32'(presence), 32'(e_pres));
            chk("R5 R6 R11", "rsp_data", 32'(rsp_data), 32'(e_rsp));
            chk("R10", "enable overlap", 32'(drive_low && spu_en), 32'd0);
        end
    end

    task automatic issue(input logic [2:0] op, input logic [7:0] d, input logic s);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_spu = s;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_spu = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL R2 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs held at zero while in reset
        chk("R1", "drive_low in reset", 32'(drive_low), 0);
        chk("R1", "busy in reset", 32'(busy), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "drive_low", 32'(drive_low), 0);
        chk("R1", "spu_en", 32'(spu_en), 0);
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "presence", 32'(presence), 0);
        chk("R1", "rsp_data", 32'(rsp_data), 0);

        // R3: reset with and without a responder
        slave_on = 1'b1;
        issue(3'd1, 8'h00, 1'b0);
        chk("R3", "presence with responder", 32'(presence), 1);
        slave_on = 1'b0;
        issue(3'd1, 8'h00, 1'b1);
        chk("R3 R8", "presence without responder", 32'(presence), 0);

        // R4: single write slots of both values
        issue(3'd2, 8'h01, 1'b0);
        issue(3'd2, 8'hFE, 1'b1);

        // R5: read slots returning 0 and 1
        rd_bits.push_back(1'b0);
        issue(3'd3, 8'h00, 1'b0);
        chk("R5", "read bit 0", 32'(rsp_data), 0);
        rd_bits.push_back(1'b1);
        issue(3'd3, 8'h00, 1'b0);
        chk("R5", "read bit 1", 32'(rsp_data), 1);

        // R6: byte write and byte read, LSB first
        issue(3'd4, 8'hA5, 1'b0);
        for (int i = 0; i < 8; i++) rd_bits.push_back(bit'((8'h3C >> i) & 1));
        issue(3'd5, 8'h00, 1'b1);
        chk("R6 R8", "read byte", 32'(rsp_data), 32'h3C);

        // R7: byte write followed by strong pull-up
        issue(3'd4, 8'h5A, 1'b1);
        chk("R7", "spu_en after hold", 32'(spu_en), 0);
        chk("R11", "rsp kept over write", 32'(rsp_data), 32'h3C);

        // R2: unknown codes ignored
        @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd6;
        @(negedge clk); cmd_op = 3'd0;
        @(negedge clk); cmd_op = 3'd7;
        @(negedge clk); cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2", "busy after bad codes", 32'(busy), 0);

        // R2: request while busy ignored
        rd_bits.push_back(1'b0);
        @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd3;
        @(negedge clk); cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1;
        @(negedge clk); cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R2", "busy after ignored request", 32'(busy), 0);
        chk("R2", "read result kept", 32'(rsp_data), 0);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule